// File: doc/BRIEF.md
# Ternary Logic Unit

This block evaluates three-valued logic on a row of trits. Each trit is two bits wide. Two operand vectors, x and y, hold LANES trits each. A 4-bit opcode selects one operator, and every lane computes the same operator on its own pair of trits.

The operators are:
- minimum and maximum;
- the six literal operators on x, which test x for equality with 0, 1 or 2 and return one of the extreme truth values;
- the cycling step on x;
- ternary negation of x;
- addition and multiplication modulo 3.

Minimum and maximum together with the literals form a functionally complete set, so chains of operations through this unit can build any three-valued function.

A malformed trit is caught in the lane where it arrives. It sets that lane's error flag and the lane returns 0, while the other lanes go on working. An opcode outside the defined set returns all zeros and raises a single illegal-operation flag.

A build-time switch picks the output form. One form registers the result for one cycle and carries a valid signal alongside it. The other passes the result straight through in the same cycle.

Top module: `tern_alu`

## Requirements
- R1: Trits are encoded 00 = 0, 01 = 1, 10 = 2; lane i of each vector occupies bits [2i+1:2i]. Opcode 0 gives min(x, y) and opcode 1 gives max(x, y) in every lane, so value 0 absorbs under min and value 2 absorbs under max.
- R2: Opcodes 2, 3 and 4 give the selector of value 0, 1 and 2 respectively: the result is 2 where x equals that value and 0 otherwise.
- R3: Opcodes 5, 6 and 7 give the excluder of value 0, 1 and 2 respectively: the result is 0 where x equals that value and 2 otherwise.
- R4: Opcode 8 gives (x + 1) mod 3. Opcode 9 gives the negation, which swaps 0 and 2 and keeps 1.
- R5: Opcode 10 gives (x + y) mod 3 and opcode 11 gives (x * y) mod 3.
- R6: Composed through the unit, for every x: max(sel0(x), sel2(x)) equals exc1(x), and max(min(sel2(x), 2), min(sel1(x), 1)) equals x.
- R7: A lane whose x trit is 11 sets its error bit and outputs 00. So does a lane running a two-operand opcode (0, 1, 10, 11) whose y trit is 11. The y trit is ignored by one-operand opcodes. Other lanes are unaffected.
- R8: Opcodes 12 to 15 output 00 in every lane, raise the illegal-operation flag, and clear all lane error bits.
- R9: In the registered form, outputs reflect the inputs of the previous clock edge, and out_valid follows in_valid by one cycle. Synchronous active-high reset clears the results, the flags and out_valid.
- R10: In the combinational form, outputs and out_valid reflect the current inputs with no clock delay.
- R11: No output lane ever presents the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the registered form) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are meaningful |
| opcode | input | 4 | Operator select |
| x_in | input | 2*LANES | First operand trits |
| y_in | input | 2*LANES | Second operand trits |
| res_out | output | 2*LANES | Result trits |
| lane_err | output | LANES | Per-lane malformed-input flag |
| illegal_op | output | 1 | Opcode outside the defined set |
| out_valid | output | 1 | Result qualifier |

## Verification
The bench builds two copies of the block at the same time.

The first copy has three lanes and the registered form. With more than one lane, a malformed trit can be placed next to healthy lanes, which tests lane independence. The registered form exercises the one-cycle delay, the valid pipeline and reset.

The second copy has a single lane in combinational form. It covers the pass-through variant. It also lets the bench chain results back into the unit within one cycle, so the two operator identities can be checked exhaustively over every x.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_ONE  = 2'b01;
    localparam trit_t T_TWO  = 2'b10;
    localparam trit_t T_BAD  = 2'b11;

    localparam logic [3:0] OP_MIN  = 4'd0;
    localparam logic [3:0] OP_MAX  = 4'd1;
    localparam logic [3:0] OP_SEL0 = 4'd2;
    localparam logic [3:0] OP_SEL1 = 4'd3;
    localparam logic [3:0] OP_SEL2 = 4'd4;
    localparam logic [3:0] OP_EXC0 = 4'd5;
    localparam logic [3:0] OP_EXC1 = 4'd6;
    localparam logic [3:0] OP_EXC2 = 4'd7;
    localparam logic [3:0] OP_ROT  = 4'd8;
    localparam logic [3:0] OP_NEG  = 4'd9;
    localparam logic [3:0] OP_ADD3 = 4'd10;
    localparam logic [3:0] OP_MUL3 = 4'd11;

    typedef struct packed {
        trit_t val;
        logic  err;
    } lane_out_t;

    function automatic logic op_legal(input logic [3:0] op);
        return op <= OP_MUL3;
    endfunction

    function automatic logic op_binary(input logic [3:0] op);
        return (op == OP_MIN) || (op == OP_MAX) || (op == OP_ADD3) || (op == OP_MUL3);
    endfunction

    function automatic trit_t t_min(input trit_t a, input trit_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic trit_t t_max(input trit_t a, input trit_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic trit_t t_sel(input trit_t a, input trit_t k);
        return (a == k) ? T_TWO : T_ZERO;
    endfunction

    function automatic trit_t t_exc(input trit_t a, input trit_t k);
        return (a == k) ? T_ZERO : T_TWO;
    endfunction

    function automatic trit_t t_rot(input trit_t a);
        return (a == T_TWO) ? T_ZERO : a + 2'd1;
    endfunction

    function automatic trit_t t_neg(input trit_t a);
        return T_TWO - a;
    endfunction

    function automatic trit_t t_add(input trit_t a, input trit_t b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s >= 3'd3) ? trit_t'(s - 3'd3) : s[1:0];
    endfunction

    function automatic trit_t t_mul(input trit_t a, input trit_t b);
        if (a == T_ZERO || b == T_ZERO) return T_ZERO;
        if (a == T_ONE) return b;
        if (b == T_ONE) return a;
        return T_ONE;
    endfunction

endpackage

// File: rtl/tern_lane.sv
module tern_lane
    import tern_pkg::*;
(
    input  logic [3:0] op,
    input  trit_t      a,
    input  trit_t      b,
    output lane_out_t  o
);
    logic bad;

    always_comb begin
        bad   = (a == T_BAD) || (op_binary(op) && (b == T_BAD));
        o.val = T_ZERO;
        o.err = 1'b0;
        if (op_legal(op)) begin
            if (bad) begin
                o.err = 1'b1;
            end else begin
                case (op)
                    OP_MIN:  o.val = t_min(a, b);
                    OP_MAX:  o.val = t_max(a, b);
                    OP_SEL0: o.val = t_sel(a, T_ZERO);
                    OP_SEL1: o.val = t_sel(a, T_ONE);
                    OP_SEL2: o.val = t_sel(a, T_TWO);
                    OP_EXC0: o.val = t_exc(a, T_ZERO);
                    OP_EXC1: o.val = t_exc(a, T_ONE);
                    OP_EXC2: o.val = t_exc(a, T_TWO);
                    OP_ROT:  o.val = t_rot(a);
                    OP_NEG:  o.val = t_neg(a);
                    OP_ADD3: o.val = t_add(a, b);
                    OP_MUL3: o.val = t_mul(a, b);
                    default: o.val = T_ZERO;
                endcase
            end
        end
    end
endmodule

// File: rtl/tern_out_stage.sv
module tern_out_stage #(
    parameter int W          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_in,
    input  logic [W-1:0] d,
    output logic         v_out,
    output logic [W-1:0] q
);
    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q     <= '0;
                    v_out <= 1'b0;
                end else begin
                    q     <= d;
                    v_out <= v_in;
                end
            end
        end else begin : g_comb
            assign q     = d;
            assign v_out = v_in;
        end
    endgenerate
endmodule

// File: rtl/tern_alu.sv
module tern_alu
    import tern_pkg::*;
#(
    parameter int LANES      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [3:0]         opcode,
    input  logic [2*LANES-1:0] x_in,
    input  logic [2*LANES-1:0] y_in,
    output logic [2*LANES-1:0] res_out,
    output logic [LANES-1:0]   lane_err,
    output logic               illegal_op,
    output logic               out_valid
);
    localparam int VW = 2 * LANES;
    localparam int SW = VW + LANES + 1;

    logic [VW-1:0]    c_val;
    logic [LANES-1:0] c_err;
    logic             c_ill;
    logic [SW-1:0]    s_q;

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            lane_out_t lo;
            tern_lane u_lane (
                .op (opcode),
                .a  (x_in[2*i +: 2]),
                .b  (y_in[2*i +: 2]),
                .o  (lo)
            );
            assign c_val[2*i +: 2] = lo.val;
            assign c_err[i]        = lo.err;
        end
    endgenerate

    assign c_ill = !op_legal(opcode);

    tern_out_stage #(.W(SW), .REGISTERED(REGISTERED)) u_stage (
        .clk   (clk),
        .rst   (rst),
        .v_in  (in_valid),
        .d     ({c_ill, c_err, c_val}),
        .v_out (out_valid),
        .q     (s_q)
    );

    assign res_out    = s_q[VW-1:0];
    assign lane_err   = s_q[VW +: LANES];
    assign illegal_op = s_q[SW-1];

    generate
        for (i = 0; i < LANES; i++) begin : g_chk
            AST_ERR_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
                lane_err[i] |-> (res_out[2*i +: 2] == 2'b00)); // R7
            AST_TRIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
                res_out[2*i +: 2] != 2'b11); // R11
        end
        if (REGISTERED) begin : g_vchk
            AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid); // R9
            AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid); // R9
        end
    endgenerate

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (res_out == '0 && lane_err == '0)); // R8

endmodule

// File: tb/sim_tern_alu.sv
module sim_tern_alu;
    localparam int NL = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [3:0]    opcode = '0;
    logic [2*NL-1:0] x_in = '0, y_in = '0;
    logic [2*NL-1:0] res_out;
    logic [NL-1:0] lane_err;
    logic          illegal_op, out_valid;

    logic [3:0] c_op = '0;
    logic [1:0] c_x = '0, c_y = '0, c_res;
    logic [0:0] c_err;
    logic       c_ill, c_vld;
    logic       c_in_valid = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int  px [NL];
    int  py [NL];
    int  p_res [NL];
    bit  p_err [NL];
    bit  p_ill = 0;
    bit  p_vld = 0;

    always #5 clk = ~clk;

    tern_alu #(.LANES(NL), .REGISTERED(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .x_in(x_in), .y_in(y_in), .res_out(res_out), .lane_err(lane_err),
        .illegal_op(illegal_op), .out_valid(out_valid));

    tern_alu #(.LANES(1), .REGISTERED(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_valid(c_in_valid), .opcode(c_op),
        .x_in(c_x), .y_in(c_y), .res_out(c_res), .lane_err(c_err),
        .illegal_op(c_ill), .out_valid(c_vld));

    function automatic bit is_bin(int op);
        return op == 0 || op == 1 || op == 10 || op == 11;
    endfunction

    function automatic string req_of(int op);
        case (op)
            0, 1:       return "R1";
            2, 3, 4:    return "R2";
            5, 6, 7:    return "R3";
            8, 9:       return "R4";
            10, 11:     return "R5";
            default:    return "R8";
        endcase
    endfunction

    // behavioural reference: returns value, sets err/ill
    function automatic int model(int op, int a, int b, output bit err, output bit ill);
        ill = (op > 11);
        err = 0;
        if (ill) return 0;
        if (a == 3 || (is_bin(op) && b == 3)) begin
            err = 1;
            return 0;
        end
        case (op)
            0:  return (a < b) ? a : b;
            1:  return (a > b) ? a : b;
            2, 3, 4: return (a == op - 2) ? 2 : 0;
            5, 6, 7: return (a == op - 5) ? 0 : 2;
            8:  return (a + 1) % 3;
            9:  return 2 - a;
            10: return (a + b) % 3;
            default: return (a * b) % 3;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_reg();
        for (int i = 0; i < NL; i++) begin
            string rq;
            rq = p_err[i] ? "R7" : (p_vld || p_ill ? req_of(int'(opcode)) : "R9");
            rq = "R9";
            chk(int'(res_out[2*i +: 2]) == p_res[i], rq, "reg lane value",
                int'(res_out[2*i +: 2]), p_res[i]);
            chk(lane_err[i] == p_err[i], "R7", "reg lane error", int'(lane_err[i]), int'(p_err[i]));
        end
        chk(illegal_op == p_ill, "R8", "reg illegal flag", int'(illegal_op), int'(p_ill));
        chk(out_valid == p_vld, "R9", "reg out_valid", int'(out_valid), int'(p_vld));
    endtask

    // drive one cycle of stimulus at a falling edge
    task automatic cycle(int op, bit vld);
        bit e, il;
        int v;
        check_reg();
        opcode   = 4'(op);
        in_valid = vld;
        for (int i = 0; i < NL; i++) begin
            x_in[2*i +: 2] = 2'(px[i]);
            y_in[2*i +: 2] = 2'(py[i]);
            p_res[i] = model(op, px[i], py[i], e, il);
            p_err[i] = e;
            p_ill    = il;
        end
        p_vld = vld;
        c_op = 4'(op);
        c_x = 2'(px[0]);
        c_y = 2'(py[0]);
        c_in_valid = vld;
        #1;
        v = model(op, px[0], py[0], e, il);
        chk(int'(c_res) == v, (e ? "R7" : req_of(op)), "comb value (R10)", int'(c_res), v);
        chk(c_err[0] == e, "R7", "comb lane error", int'(c_err[0]), int'(e));
        chk(c_ill == il, "R8", "comb illegal flag", int'(c_ill), int'(il));
        chk(c_vld == vld, "R10", "comb out_valid", int'(c_vld), int'(vld));
        @(negedge clk);
    endtask

    task automatic ceval(int op, int a, int b, output int r);
        c_op = 4'(op);
        c_x  = 2'(a);
        c_y  = 2'(b);
        #1;
        r = int'(c_res);
    endtask

    function automatic int rtrit();
        return ($urandom_range(0, 9) == 0) ? 3 : int'($urandom_range(0, 2));
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < NL; i++) begin
            p_res[i] = 0;
            p_err[i] = 0;
            px[i] = 0;
            py[i] = 0;
        end
        repeat (3) @(negedge clk);
        // reset state (R9): outputs cleared while reset is held
        check_reg();
        rst = 1'b0;
        // directed sweep of every opcode over every trit pair, incl. code 11
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++) begin
                    px[0] = a; py[0] = b;
                    px[1] = b; py[1] = a;
                    px[2] = rtrit(); py[2] = rtrit();
                    cycle(op, 1'b1);
                end
        // random traffic with gaps in in_valid
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < NL; i++) begin
                px[i] = rtrit();
                py[i] = rtrit();
            end
            cycle(int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)));
        end
        // reset in mid-stream clears outputs (R9)
        px[0] = 2; py[0] = 2;
        cycle(1, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            p_res[i] = 0;
            p_err[i] = 0;
        end
        p_ill = 0;
        p_vld = 0;
        check_reg();
        rst = 1'b0;
        // R6: identities composed through the combinational copy
        for (int x = 0; x < 3; x++) begin
            int s0, s1, s2, e1, m, a2, a1, rec;
            ceval(2, x, 0, s0);
            ceval(4, x, 0, s2);
            ceval(1, s0, s2, m);
            ceval(6, x, 0, e1);
            chk(m == e1, "R6", "sel0 max sel2 vs exc1", m, e1);
            ceval(3, x, 0, s1);
            ceval(0, s2, 2, a2);
            ceval(0, s1, 1, a1);
            ceval(1, a2, a1, rec);
            chk(rec == x, "R6", "reconstruction of x", rec, x);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule